// File: doc/BRIEF.md
# Mode-banked register file

This block stores the general registers and status words of a 32-bit processor whose register set changes with its operating mode. Sixteen architectural indices are visible at any time. Index 15 (the program counter) and the current status word are common to every mode. Some of the lower indices reach private copies depending on a 5-bit mode code kept in bits 4:0 of the current status word. The fast-interrupt mode has a private copy of indices 8 to 14. Four other privileged modes each keep a private copy of index 13 (stack pointer) and index 14 (link register). User and system modes share one base bank.

Two combinational read ports and one clocked write port take a 4-bit architectural index. The write port uses the mode held in the current status word during the cycle of the write. Each of the five exception modes also has a saved status word, and only the copy that belongs to the current mode can be reached. Status writes go through a per-bit mask combined with a fixed set of writable bits, so a flag-only or control-only update leaves every other bit untouched. All pins are plain level signals: a register access completes in a single cycle, so there is no valid/ready handshake and no back-pressure.

Top module: `bankreg_file`

## Requirements
- R1: A synchronous reset, sampled on the rising edge, sets the current status word to 32'h0000_0013 (supervisor mode) and clears every general register and every saved status word to zero.
- R2: Mode codes in bits 4:0 of the current status word: 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined, 11111 system. User and system modes reach one shared base bank for indices 0 to 14.
- R3: In fast-interrupt mode, indices 8 to 14 reach a private set of seven registers, and indices 0 to 7 reach the base bank.
- R4: In interrupt, supervisor, abort and undefined modes, indices 13 and 14 reach a private pair for that mode, and indices 0 to 12 reach the base bank.
- R5: Index 15 reaches one register that is common to every mode.
- R6: A mode code outside the seven listed codes maps every index to the base bank.
- R7: Each of the five exception modes has its own saved status word. The saved-status read and write ports reach only the word of the current mode.
- R8: In user, system or an unrecognised mode, the saved-status read port returns zero and saved-status writes have no effect.
- R9: On a status write, a bit takes the new data only where its mask bit is 1 and it is writable. All other bits keep their old value.
- R10: The writable status bits are set by the STATUS_WRITABLE parameter (default: bits 31:28 and 7:0). Reserved bits never change after reset and read zero.
- R11: Both read ports are combinational in the current mode and the index, and they work independently.
- R12: When a read port addresses the same physical register that the write port is writing in that cycle, the read port returns the write data.
- R13: A general-register write lands in the bank selected by the mode present in the cycle of the write, even when the current status word changes mode at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Architectural index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Architectural index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General-register write enable |
| wr_idx | input | 4 | Architectural index to write |
| wr_data | input | 32 | Write data |
| cur_wr_en | input | 1 | Current status write enable |
| cur_wr_data | input | 32 | Current status write data |
| cur_wr_mask | input | 32 | Per-bit mask for the current status write |
| cur_status | output | 32 | Current status word; bits 4:0 hold the mode |
| sav_wr_en | input | 1 | Saved status write enable (current mode's word) |
| sav_wr_data | input | 32 | Saved status write data |
| sav_wr_mask | input | 32 | Per-bit mask for the saved status write |
| sav_status | output | 32 | Saved status word of the current mode |

## Verification
Each of the seven legal modes and one illegal code takes a turn writing a value to all sixteen indices. The value encodes the writing mode and the index. Every index is then read back on both ports in every mode, so any bank that leaks into another, or any missing share, shows up as the wrong encoded value. A second sweep does the same for the saved status words, including writes from modes that have none, which must leave all five words untouched. Directed cases cover partial-mask status updates, the reserved bits, a read that hits the write in the same cycle, and a write that coincides with a mode change.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  localparam int ARCH_REGS   = 16;
  localparam int PC_IDX      = ARCH_REGS - 1;
  localparam int FIQ_FIRST   = 8;
  localparam int PAIR_FIRST  = 13;
  localparam int FIQ_BANKED  = PC_IDX - FIQ_FIRST;
  localparam int PAIR_BANKED = PC_IDX - PAIR_FIRST;
  localparam int NUM_SAVED   = 5;
  localparam int SAVED_W     = $clog2(NUM_SAVED);
  localparam int FIQ_BASE    = ARCH_REGS;
  localparam int PAIR_BASE   = FIQ_BASE + FIQ_BANKED;
  localparam int NUM_PHYS    = PAIR_BASE + (NUM_SAVED - 1) * PAIR_BANKED;

  // {valid, slot}: slot 0 is fast interrupt, 1..4 are the pair-banked modes
  function automatic logic [SAVED_W:0] saved_slot(input logic [4:0] m);
    logic [SAVED_W:0] r;
    case (m)
      MODE_FIQ: r = {1'b1, SAVED_W'(0)};
      MODE_IRQ: r = {1'b1, SAVED_W'(1)};
      MODE_SVC: r = {1'b1, SAVED_W'(2)};
      MODE_ABT: r = {1'b1, SAVED_W'(3)};
      MODE_UND: r = {1'b1, SAVED_W'(4)};
      default:  r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bankreg_map.sv
`timescale 1ns/1ps
module bankreg_map
  import bankreg_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic [4:0]    mode,
  input  logic [3:0]    idx,
  output logic [PW-1:0] phys
);

  logic [SAVED_W:0] sl;
  assign sl = saved_slot(mode);

  always_comb begin
    phys = PW'(idx);
    if (int'(idx) != PC_IDX && sl[SAVED_W]) begin
      if (sl[SAVED_W-1:0] == '0) begin
        if (int'(idx) >= FIQ_FIRST)
          phys = PW'(FIQ_BASE + int'(idx) - FIQ_FIRST);
      end else if (int'(idx) >= PAIR_FIRST) begin
        phys = PW'(PAIR_BASE + (int'(sl[SAVED_W-1:0]) - 1) * PAIR_BANKED
                   + int'(idx) - PAIR_FIRST);
      end
    end
  end

endmodule

// File: rtl/bankreg_gpr.sv
`timescale 1ns/1ps
module bankreg_gpr #(
  parameter int XLEN     = 32,
  parameter int NUM_PHYS = 31,
  parameter int NUM_RD   = 2,
  parameter int PW       = $clog2(NUM_PHYS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [PW-1:0]                  wr_phys,
  input  logic [XLEN-1:0]                wr_data,
  input  logic [NUM_RD-1:0][PW-1:0]      rd_phys,
  output logic [NUM_RD-1:0][XLEN-1:0]    rd_data
);

  logic [XLEN-1:0] regs [NUM_PHYS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_en && wr_phys == PW'(i))
        regs[i] <= wr_data;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      if (wr_en && wr_phys == rd_phys[p])
        rd_data[p] = wr_data;
      else
        rd_data[p] = regs[rd_phys[p]];
    end
  end

endmodule

// File: rtl/bankreg_status.sv
`timescale 1ns/1ps
module bankreg_status
  import bankreg_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] WRITABLE  = 32'hF000_00FF,
  parameter logic [XLEN-1:0] RESET_VAL = 32'h0000_0013
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cur_wr_en,
  input  logic [XLEN-1:0] cur_wr_data,
  input  logic [XLEN-1:0] cur_wr_mask,
  input  logic            sav_wr_en,
  input  logic [XLEN-1:0] sav_wr_data,
  input  logic [XLEN-1:0] sav_wr_mask,
  output logic [XLEN-1:0] cur_q,
  output logic [XLEN-1:0] sav_rd
);

  logic [XLEN-1:0]  saved [NUM_SAVED];
  logic [SAVED_W:0] sl;
  logic [XLEN-1:0]  cur_m, sav_m;

  assign sl    = saved_slot(cur_q[4:0]);
  assign cur_m = cur_wr_mask & WRITABLE;
  assign sav_m = sav_wr_mask & WRITABLE;

  always_ff @(posedge clk) begin
    if (rst)
      cur_q <= RESET_VAL;
    else if (cur_wr_en)
      cur_q <= (cur_q & ~cur_m) | (cur_wr_data & cur_m);
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SAVED; s++) begin
      if (rst)
        saved[s] <= '0;
      else if (sav_wr_en && sl[SAVED_W] && sl[SAVED_W-1:0] == SAVED_W'(s))
        saved[s] <= (saved[s] & ~sav_m) | (sav_wr_data & sav_m);
    end
  end

  assign sav_rd = sl[SAVED_W] ? saved[sl[SAVED_W-1:0]] : '0;

endmodule

// File: rtl/bankreg_file.sv
`timescale 1ns/1ps
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int              XLEN            = 32,
  parameter logic [XLEN-1:0] STATUS_WRITABLE = 32'hF000_00FF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            cur_wr_en,
  input  logic [XLEN-1:0] cur_wr_data,
  input  logic [XLEN-1:0] cur_wr_mask,
  output logic [XLEN-1:0] cur_status,
  input  logic            sav_wr_en,
  input  logic [XLEN-1:0] sav_wr_data,
  input  logic [XLEN-1:0] sav_wr_mask,
  output logic [XLEN-1:0] sav_status
);

  localparam int PW     = $clog2(NUM_PHYS);
  localparam int NUM_RD = 2;
  localparam int NUM_AP = NUM_RD + 1;
  localparam logic [XLEN-1:0] RESET_VAL = XLEN'(MODE_SVC);

  logic [4:0]                    cur_mode;
  logic [NUM_AP-1:0][3:0]        map_idx;
  logic [NUM_AP-1:0][PW-1:0]     map_phys;
  logic [NUM_RD-1:0][XLEN-1:0]   rd_data;

  assign cur_mode   = cur_status[4:0];
  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar g = 0; g < NUM_AP; g++) begin : g_map
    bankreg_map #(.PW(PW)) u_map (
      .mode (cur_mode),
      .idx  (map_idx[g]),
      .phys (map_phys[g])
    );
  end

  bankreg_gpr #(
    .XLEN(XLEN), .NUM_PHYS(NUM_PHYS), .NUM_RD(NUM_RD), .PW(PW)
  ) u_gpr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_phys (map_phys[NUM_RD]),
    .wr_data (wr_data),
    .rd_phys (map_phys[NUM_RD-1:0]),
    .rd_data (rd_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  bankreg_status #(
    .XLEN(XLEN), .WRITABLE(STATUS_WRITABLE), .RESET_VAL(RESET_VAL)
  ) u_status (
    .clk         (clk),
    .rst         (rst),
    .cur_wr_en   (cur_wr_en),
    .cur_wr_data (cur_wr_data),
    .cur_wr_mask (cur_wr_mask),
    .sav_wr_en   (sav_wr_en),
    .sav_wr_data (sav_wr_data),
    .sav_wr_mask (sav_wr_mask),
    .cur_q       (cur_status),
    .sav_rd      (sav_status)
  );

endmodule

// File: rtl/bankreg_checker.sv
`timescale 1ns/1ps
module bankreg_checker #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] WRITABLE = 32'hF000_00FF
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic            wr_en,
  input logic [3:0]      wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic            cur_wr_en,
  input logic [XLEN-1:0] cur_wr_mask,
  input logic [XLEN-1:0] cur_status,
  input logic [XLEN-1:0] sav_status
);

  logic rst_q;
  logic has_saved;

  always_ff @(posedge clk) rst_q <= rst;

  assign has_saved = cur_status[4:0] inside {5'b10001, 5'b10010, 5'b10011,
                                             5'b10111, 5'b11011};

  p_reset_mode_r1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> cur_status == XLEN'(5'b10011));

  p_no_saved_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !has_saved |-> sav_status == '0);

  p_mask_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(cur_wr_en) && !$past(rst)) |->
      ((cur_status ^ $past(cur_status)) & ~$past(cur_wr_mask)) == '0);

  p_reserved_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cur_status ^ $past(cur_status)) & ~WRITABLE) == '0);

  p_bypass_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == rd_a_idx) |-> rd_a_data == wr_data);

  p_write_lands_r13: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && $stable(cur_status[4:0]) &&
     rd_a_idx == $past(wr_idx) && !(wr_en && wr_idx == rd_a_idx))
      |-> rd_a_data == $past(wr_data));

endmodule

bind bankreg_file bankreg_checker #(.XLEN(XLEN), .WRITABLE(STATUS_WRITABLE)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .cur_wr_en   (cur_wr_en),
  .cur_wr_mask (cur_wr_mask),
  .cur_status  (cur_status),
  .sav_status  (sav_status)
);

// File: tb/test_bankreg_file.sv
`timescale 1ns/1ps
module test_bankreg_file;

  localparam logic [31:0] WR_BITS = 32'hF000_00FF;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, cur_wr_en, sav_wr_en;
  logic [31:0] cur_wr_data, cur_wr_mask, cur_status;
  logic [31:0] sav_wr_data, sav_wr_mask, sav_status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] mdl [31];
  logic [31:0] smdl [5];
  logic [4:0]  modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                            5'b10111, 5'b11011, 5'b11111, 5'b00000};

  always #2 clk = ~clk;

  bankreg_file i_bankreg_file (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cur_wr_en(cur_wr_en), .cur_wr_data(cur_wr_data), .cur_wr_mask(cur_wr_mask),
    .cur_status(cur_status),
    .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data), .sav_wr_mask(sav_wr_mask),
    .sav_status(sav_status)
  );

  // expected storage slot, derived from R2-R6
  function automatic int slot_of(logic [4:0] m, int idx);
    if (idx == 15) return 15;
    case (m)
      5'b10001: if (idx >= 8)  return 16 + idx - 8;
      5'b10010: if (idx >= 13) return 23 + idx - 13;
      5'b10011: if (idx >= 13) return 25 + idx - 13;
      5'b10111: if (idx >= 13) return 27 + idx - 13;
      5'b11011: if (idx >= 13) return 29 + idx - 13;
      default: ;
    endcase
    return idx;
  endfunction

  function automatic int sav_of(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_status(logic [31:0] d, logic [31:0] m);
    @(negedge clk);
    cur_wr_en = 1'b1; cur_wr_data = d; cur_wr_mask = m;
    @(negedge clk);
    cur_wr_en = 1'b0;
  endtask

  task automatic set_mode(logic [4:0] m);
    set_status({27'd0, m}, 32'h0000_001F);
  endtask

  task automatic gpr_write(int idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sav_write(logic [31:0] d, logic [31:0] m);
    @(negedge clk);
    sav_wr_en = 1'b1; sav_wr_data = d; sav_wr_mask = m;
    @(negedge clk);
    sav_wr_en = 1'b0;
  endtask

  task automatic read2(int ia, int ib);
    @(negedge clk);
    rd_a_idx = 4'(ia); rd_b_idx = 4'(ib);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; cur_wr_en = 1'b0; sav_wr_en = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0;
    cur_wr_data = '0; cur_wr_mask = '0; sav_wr_data = '0; sav_wr_mask = '0;
    for (int i = 0; i < 31; i++) mdl[i] = '0;
    for (int i = 0; i < 5; i++) smdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    #1;
    check("R1 status", cur_status, 32'h0000_0013);
    check("R1 saved", sav_status, 32'h0);
    for (int i = 0; i < 16; i++) begin
      read2(i, 15 - i);
      check("R1 regA", rd_a_data, 32'h0);
      check("R1 regB", rd_b_data, 32'h0);
    end

    // R2-R6, R11: write every index in every mode, then read all back
    for (int k = 0; k < 8; k++) begin
      set_mode(modes[k]);
      check("R2 mode set", cur_status, {27'd0, modes[k]});
      for (int i = 0; i < 16; i++) begin
        logic [31:0] v;
        v = {3'd0, modes[k], 8'(k), 8'(i), 8'h5A};
        gpr_write(i, v);
        mdl[slot_of(modes[k], i)] = v;
      end
    end
    for (int k = 0; k < 8; k++) begin
      set_mode(modes[k]);
      for (int i = 0; i < 16; i++) begin
        read2(i, 15 - i);
        check("R2-R6 sweep A (R3 R4 R5 R6 R11)", rd_a_data, mdl[slot_of(modes[k], i)]);
        check("R11 sweep B", rd_b_data, mdl[slot_of(modes[k], 15 - i)]);
      end
    end

    // R7, R8: saved status sweep, writes in all modes
    for (int k = 0; k < 8; k++) begin
      logic [31:0] v;
      set_mode(modes[k]);
      v = {4'hA ^ 4'(k), 20'hFFFFF, 3'(k), modes[k]};
      sav_write(v, 32'hFFFF_FFFF);
      if (sav_of(modes[k]) >= 0) smdl[sav_of(modes[k])] = v & WR_BITS;
    end
    for (int k = 0; k < 8; k++) begin
      set_mode(modes[k]);
      #1;
      if (sav_of(modes[k]) >= 0)
        check("R7 saved per mode", sav_status, smdl[sav_of(modes[k])]);
      else
        check("R8 saved zero", sav_status, 32'h0);
    end

    // R9: masked saved write in interrupt mode
    set_mode(5'b10010);
    sav_write(32'h0000_0000, 32'hF000_0000);
    smdl[1] = smdl[1] & 32'h0FFF_FFFF;
    #1;
    check("R9 saved mask", sav_status, smdl[1]);

    // R9, R10: current status masked writes and reserved bits
    set_mode(5'b10011);
    set_status(32'hFFFF_FFFF, 32'hF000_0000);
    check("R9 flags only", cur_status, 32'hF000_0013);
    set_status(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R10 reserved", cur_status, 32'hF000_00FF);
    set_status(32'h0000_0000, 32'h0000_00E0);
    check("R9 control only", cur_status, 32'hF000_001F);
    set_mode(5'b10011);
    check("R9 mode only", cur_status, 32'hF000_0013);

    // R12: same-cycle read of the register being written
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hCAFE_0001;
    rd_a_idx = 4'd13; rd_b_idx = 4'd14;
    #1;
    check("R12 bypass A", rd_a_data, 32'hCAFE_0001);
    check("R12 other B", rd_b_data, mdl[slot_of(5'b10011, 14)]);
    @(negedge clk);
    wr_en = 1'b0;
    mdl[slot_of(5'b10011, 13)] = 32'hCAFE_0001;
    read2(13, 13);
    check("R12 stored", rd_a_data, 32'hCAFE_0001);

    // R13: write coinciding with a switch to user mode
    @(negedge clk);
    cur_wr_en = 1'b1; cur_wr_data = 32'h0000_0010; cur_wr_mask = 32'h0000_001F;
    wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h1357_9BDF;
    @(negedge clk);
    cur_wr_en = 1'b0; wr_en = 1'b0;
    mdl[slot_of(5'b10011, 14)] = 32'h1357_9BDF;
    check("R13 now user", cur_status, 32'hF000_0010);
    read2(14, 13);
    check("R13 user untouched", rd_a_data, mdl[14]);
    set_mode(5'b10011);
    read2(14, 13);
    check("R13 old bank got write", rd_a_data, 32'h1357_9BDF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule